// File: doc/BRIEF.md
# Biphase Infrared Frame Transmitter

This block serialises a 5-bit system code and a 6-bit command code into a 14-bit frame for an infrared remote control. Each bit is sent in biphase form, so every bit period has a transition at its midpoint. The block drives two lines. One is the baseband code. The other is the same code gated by a carrier that runs at one twelfth of the oscillator clock and is high for a quarter of each carrier period. Every frame starts with two start bits, continues with a toggle bit, and ends with the two code fields.

A transmit request is a valid/ready handshake that carries the two code fields. The block raises `in_ready` only while it is idle, or in the last clock of a repetition period. A source that asserts `in_valid` must hold the request and its fields steady until the cycle in which `in_ready` is also high. A request is accepted in that cycle and in no other. While `key_held` stays high, the frame is sent again every repetition period with the same codes. Once `key_held` falls, the frame in progress completes and no further frame is started. The toggle bit flips on every accepted request, so a receiver can tell a fresh press from a repeat of the same press.

Top module: `biphase_ir_tx`

## Requirements
- R1: After reset both outputs are low, `in_ready` is high, and the stored toggle is 0, so the first accepted frame carries toggle 1.
- R2: One bit period lasts BIT_CYCLES clocks (default 768). It is split into two equal halves. Half 0 of bit 0 covers the BIT_CYCLES/2 clocks that begin on the cycle after the accepting edge.
- R3: A logic 1 is sent as low in the first half and high in the second half. A logic 0 is sent as high in the first half and low in the second half.
- R4: A frame is 14 bits, sent in this order: 1, 1, toggle, system code from bit 4 down to bit 0, then command code from bit 5 down to bit 0.
- R5: A request is accepted when `in_valid` and `in_ready` are both high. The code fields are captured on that edge and do not change while the frame is sent.
- R6: If `key_held` is high at the end of a frame and again at the end of a period of PERIOD_BITS bit times (default 64), the same frame, with the same toggle, starts again on the next clock. The code line is low for the rest of the period after the frame.
- R7: If `key_held` is low at the end of the frame, the block goes idle after that frame. From then on both outputs stay low and no further frame is sent.
- R8: The toggle bit is inverted on every accepted request.
- R9: `in_ready` is low while a frame or its gap is in progress, except in the last clock of the period. A request held pending is accepted on that clock, and the next frame carries its codes.
- R10: `mcode_o` is `code_o` ANDed with a free-running carrier that has a period of 12 clocks and is high for 3 of them. Any 12 consecutive clocks of high code therefore hold exactly 3 high carrier clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Transmit request valid |
| in_ready | output | 1 | Request can be accepted in this cycle |
| sys_code | input | 5 | System code field of the request |
| cmd_code | input | 6 | Command code field of the request |
| key_held | input | 1 | Key still pressed; enables repetition |
| code_o | output | 1 | Baseband biphase code line |
| mcode_o | output | 1 | Carrier-gated code line |

## Verification
The hardest case to reach from the ports is a new request that sits pending through a whole repetition period and is taken on the single boundary clock. Only that clock may accept it, and the toggle must flip there. The bench holds `key_held` high and raises `in_valid` with new fields just before the first frame ends. It checks that `in_ready` stays low through the gap and rises on exactly the last clock of the period. It then checks that the next frame carries the new fields and the inverted toggle. The bench uses a short bit period, so several full periods fit in one run.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // Line level for one half of a biphase bit: a one is low then high,
  // a zero is high then low.
  function automatic logic biphase_level(input logic value, input logic second_half);
    return ~(second_half ^ value);
  endfunction

endpackage

// File: rtl/ir_carrier.sv
module ir_carrier #(
  parameter int DIV  = 12,
  parameter int HIGH = 3
) (
  input  logic clk,
  input  logic rst,
  output logic carrier_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == CW'(DIV - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign carrier_o = (phase < CW'(HIGH));
endmodule

// File: rtl/ir_slot_timer.sv
module ir_slot_timer #(
  parameter int HALF_CYC    = 384,
  parameter int PERIOD_BITS = 64,
  parameter int FRAME_BITS  = 14,
  localparam int CW = $clog2(HALF_CYC),
  localparam int SW = $clog2(PERIOD_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  output logic          second_half,
  output logic [SW-1:0] slot,
  output logic          frame_end,
  output logic          period_end
);
  logic [CW-1:0] cnt;
  logic          half_last;

  assign half_last  = (cnt == CW'(HALF_CYC - 1));
  assign frame_end  = run & half_last & second_half & (slot == SW'(FRAME_BITS - 1));
  assign period_end = run & half_last & second_half & (slot == SW'(PERIOD_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt         <= '0;
      second_half <= 1'b0;
      slot        <= '0;
    end else if (half_last) begin
      cnt <= '0;
      if (second_half) begin
        second_half <= 1'b0;
        slot        <= slot + 1'b1;
      end else begin
        second_half <= 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ir_frame_seq.sv
module ir_frame_seq
  import ir_tx_pkg::*;
#(
  parameter int SYS_W = 5,
  parameter int CMD_W = 6,
  localparam int FW = 3 + SYS_W + CMD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYS_W-1:0] sys_code,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             key_held,
  input  logic             frame_end,
  input  logic             period_end,
  output logic             sending,
  output logic             restart,
  output logic [FW-1:0]    frame_word
);
  tx_state_e state, state_nx;
  logic      toggle;
  logic      take_req;
  logic      go_again;

  assign in_ready = (state == ST_IDLE) | period_end;
  assign take_req = in_valid & in_ready;
  assign go_again = period_end & ~in_valid & key_held;
  assign restart  = take_req | go_again;
  assign sending  = (state == ST_SEND);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (take_req) state_nx = ST_SEND;
      ST_SEND: begin
        if (restart)                     state_nx = ST_SEND;
        else if (period_end)             state_nx = ST_IDLE;
        else if (frame_end && !key_held) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      toggle     <= 1'b0;
      frame_word <= '0;
    end else begin
      state <= state_nx;
      if (take_req) begin
        toggle     <= ~toggle;
        frame_word <= {2'b11, ~toggle, sys_code, cmd_code};
      end
    end
  end
endmodule

// File: rtl/biphase_ir_tx.sv
module biphase_ir_tx
  import ir_tx_pkg::*;
#(
  parameter int BIT_CYCLES  = 768,
  parameter int PERIOD_BITS = 64,
  parameter int SYS_W       = 5,
  parameter int CMD_W       = 6,
  parameter int CAR_DIV     = 12,
  parameter int CAR_HIGH    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYS_W-1:0] sys_code,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             key_held,
  output logic             code_o,
  output logic             mcode_o
);
  localparam int HALF_CYC   = BIT_CYCLES / 2;
  localparam int FRAME_BITS = 3 + SYS_W + CMD_W;
  localparam int SLOT_W     = $clog2(PERIOD_BITS);

  logic                  sending;
  logic                  restart;
  logic                  second_half;
  logic [SLOT_W-1:0]     slot;
  logic                  frame_end;
  logic                  period_end;
  logic [FRAME_BITS-1:0] frame_word;
  logic [FRAME_BITS-1:0] shifted;
  logic                  in_frame;
  logic                  carrier;

  ir_frame_seq #(.SYS_W(SYS_W), .CMD_W(CMD_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .sys_code   (sys_code),
    .cmd_code   (cmd_code),
    .key_held   (key_held),
    .frame_end  (frame_end),
    .period_end (period_end),
    .sending    (sending),
    .restart    (restart),
    .frame_word (frame_word)
  );

  ir_slot_timer #(
    .HALF_CYC    (HALF_CYC),
    .PERIOD_BITS (PERIOD_BITS),
    .FRAME_BITS  (FRAME_BITS)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run         (sending),
    .restart     (restart),
    .second_half (second_half),
    .slot        (slot),
    .frame_end   (frame_end),
    .period_end  (period_end)
  );

  ir_carrier #(.DIV(CAR_DIV), .HIGH(CAR_HIGH)) u_car (
    .clk       (clk),
    .rst       (rst),
    .carrier_o (carrier)
  );

  assign shifted  = frame_word << slot;
  assign in_frame = (slot < SLOT_W'(FRAME_BITS));
  assign code_o   = sending & in_frame & biphase_level(shifted[FRAME_BITS-1], second_half);
  assign mcode_o  = code_o & carrier;
endmodule

// File: rtl/biphase_ir_tx_chk.sv
module biphase_ir_tx_chk #(
  parameter int FW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          code_o,
  input logic          mcode_o,
  input logic          sending,
  input logic          period_end,
  input logic [FW-1:0] frame_word
);
  p_mcode_gated_r10: assert property (@(posedge clk) disable iff (rst)
    mcode_o |-> code_o);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !sending |-> (!code_o && !mcode_o));

  p_ready_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    (sending && in_ready) |-> period_end);

  p_fields_held_r5: assert property (@(posedge clk) disable iff (rst)
    (sending && !(in_valid && in_ready)) |=> $stable(frame_word));

  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (frame_word[FW-3] != $past(frame_word[FW-3])));

  p_start_bits_r4: assert property (@(posedge clk) disable iff (rst)
    sending |-> (frame_word[FW-1:FW-2] == 2'b11));
endmodule

bind biphase_ir_tx biphase_ir_tx_chk #(.FW(FRAME_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .code_o     (code_o),
  .mcode_o    (mcode_o),
  .sending    (sending),
  .period_end (period_end),
  .frame_word (frame_word)
);

// File: tb/tb_biphase_ir_tx.sv
`timescale 1ns/1ps
module tb_biphase_ir_tx;
  localparam int BITC   = 24;
  localparam int HALF   = BITC / 2;
  localparam int PERIOD = 64 * BITC;
  localparam int NBITS  = 14;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] sys_code = '0;
  logic [5:0] cmd_code = '0;
  logic       key_held = 1'b0;
  logic       code_o;
  logic       mcode_o;

  int   total = 0;
  int   bad   = 0;
  int   kpos  = 0;
  logic exp_tog = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  biphase_ir_tx #(.BIT_CYCLES(BITC)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .sys_code(sys_code), .cmd_code(cmd_code), .key_held(key_held),
    .code_o(code_o), .mcode_o(mcode_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
    kpos += n;
  endtask

  function automatic logic [13:0] mk_word(input logic tog, input logic [4:0] s, input logic [5:0] c);
    return {2'b11, tog, s, c};
  endfunction

  task automatic accept(input logic [4:0] s, input logic [5:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    sys_code = s;
    cmd_code = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    kpos = 0;
    exp_tog = ~exp_tog;
  endtask

  // Samples each half of every bit at its centre (R3 R4 R8).
  task automatic check_frame(input logic [13:0] w, input string tag);
    for (int b = 0; b < NBITS; b++) begin
      for (int h = 0; h < 2; h++) begin
        logic e;
        adv(b * BITC + h * HALF + HALF / 2 - kpos);
        e = h[0] ? w[13-b] : ~w[13-b];
        chk(code_o == e, $sformatf("R3 R4 R8 %s bit %0d half %0d", tag, b, h), code_o, e);
      end
    end
  endtask

  task automatic t_reset;
    chk(code_o == 1'b0, "R1 code low after reset", code_o, 0);
    chk(mcode_o == 1'b0, "R1 mcode low after reset", mcode_o, 0);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
  endtask

  task automatic t_bit_timing;
    key_held = 1'b0;
    accept(5'h0A, 6'h15);
    adv(HALF - 1);
    chk(code_o == 1'b0, "R2 end of first half", code_o, 0);
    adv(1);
    chk(code_o == 1'b1, "R2 start of second half", code_o, 1);
    adv(HALF - 1);
    chk(code_o == 1'b1, "R2 end of first bit", code_o, 1);
    adv(1);
    chk(code_o == 1'b0, "R2 start of second bit", code_o, 0);
    adv(NBITS * BITC + 4 - kpos);
    chk(in_ready == 1'b1, "R7 idle after released frame", in_ready, 1);
    chk(code_o == 1'b0, "R7 line low after frame", code_o, 0);
  endtask

  task automatic t_single;
    key_held = 1'b1;
    accept(5'b10110, 6'b011001);
    key_held = 1'b0;
    check_frame(mk_word(exp_tog, 5'b10110, 6'b011001), "single");
    adv(NBITS * BITC + 4 - kpos);
    chk(in_ready == 1'b1, "R7 ready after single", in_ready, 1);
    adv(PERIOD + HALF + HALF / 2 - kpos);
    chk(code_o == 1'b0, "R7 no second frame", code_o, 0);
  endtask

  task automatic t_repeat;
    logic [13:0] w;
    key_held = 1'b1;
    accept(5'b10011, 6'b000111);
    w = mk_word(exp_tog, 5'b10011, 6'b000111);
    check_frame(w, "repeat first");
    adv(400 - kpos);
    chk(code_o == 1'b0, "R6 gap low", code_o, 0);
    adv(1500 - kpos);
    chk(in_ready == 1'b0, "R9 ready low in gap", in_ready, 0);
    adv(PERIOD - kpos);
    kpos = 0;
    check_frame(w, "repeat second");
    key_held = 1'b0;
    adv(NBITS * BITC + 4 - kpos);
    chk(in_ready == 1'b1, "R7 idle after repeat", in_ready, 1);
    adv(PERIOD + HALF + HALF / 2 - kpos);
    chk(code_o == 1'b0, "R7 no third frame", code_o, 0);
  endtask

  task automatic t_hold_fields;
    key_held = 1'b1;
    accept(5'b01101, 6'b110010);
    sys_code = 5'b10010;
    cmd_code = 6'b001101;
    key_held = 1'b0;
    check_frame(mk_word(exp_tog, 5'b01101, 6'b110010), "R5 held fields");
    adv(NBITS * BITC + 4 - kpos);
  endtask

  task automatic t_midreq;
    key_held = 1'b1;
    accept(5'b11100, 6'b101010);
    check_frame(mk_word(exp_tog, 5'b11100, 6'b101010), "pending A");
    in_valid = 1'b1;
    sys_code = 5'b00011;
    cmd_code = 6'b010101;
    chk(in_ready == 1'b0, "R9 ready low mid frame", in_ready, 0);
    adv(1000 - kpos);
    chk(in_ready == 1'b0, "R9 ready low in gap", in_ready, 0);
    adv(PERIOD - 2 - kpos);
    chk(in_ready == 1'b0, "R9 ready low before boundary", in_ready, 0);
    adv(1);
    chk(in_ready == 1'b1, "R9 ready on boundary clock", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    kpos = 0;
    exp_tog = ~exp_tog;
    key_held = 1'b0;
    check_frame(mk_word(exp_tog, 5'b00011, 6'b010101), "R9 pending B");
    adv(NBITS * BITC + 4 - kpos);
    chk(in_ready == 1'b1, "R7 idle after B", in_ready, 1);
  endtask

  task automatic t_carrier;
    int hi = 0;
    int stray = 0;
    key_held = 1'b0;
    accept(5'b11111, 6'b000000);
    for (int k = 0; k < NBITS * BITC; k++) begin
      if (mcode_o) hi++;
      if (mcode_o && !code_o) stray++;
      adv(1);
    end
    chk(stray == 0, "R10 carrier only under code", stray, 0);
    chk(hi == 3 * NBITS, "R10 quarter duty carrier", hi, 3 * NBITS);
    adv(4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bit_timing();
    t_single();
    t_repeat();
    t_hold_fields();
    t_midreq();
    t_carrier();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule